// File: doc/BRIEF.md
# Register-Programmed Clock Divider Stage

This block divides a reference clock by a ratio that software sets through a 32-bit control word. The ratio is given as two independent counts, one for the low phase and one for the high phase of the output, so the output period is their sum in reference cycles. A phase-shift bit moves the output's falling edge onto the falling edge of the reference clock. For an odd ratio this evens out the duty cycle. A pass-through bit routes the reference clock straight to the output, and that is how a ratio of one is expressed.

Every control write that takes effect drops a lock flag. The output is held low for a fixed number of reference cycles and the divider restarts from its low phase. Then the flag rises again. A write whose deferral bit is set is only stored. It shows on read-back but leaves the running output and the flag alone until a later write with that bit clear takes effect.

The register bus is synchronous to the reference clock. Word address 0 holds the control register and word address 1 holds the status register. Reads are combinational.

Top module: `clkdiv_stage`

## Requirements
- R1: After reset the control register reads 0x0000_2000 (pass-through on), the status register reads 1 (locked), `locked` is 1 and `clk_out` follows `clk_ref`.
- R2: Control word fields: low count in bits [5:0], high count in bits [11:6], phase-shift in bit 12, pass-through in bit 13, deferral in bit 14; bits [31:15] are reserved. Once locked with pass-through off, `clk_out` repeats low for `low` reference cycles, then high for `high` cycles, for a period of low+high.
- R3: With an even ratio split evenly and phase-shift 0, every output transition lines up with a rising edge of `clk_ref`, giving 50% duty.
- R4: With phase-shift 1, the output's falling edge moves half a reference cycle later. The high phase gains half a cycle and the low phase loses half a cycle, so low=(N>>1)+1 and high=N>>1 give an odd ratio N with 50% duty.
- R5: With pass-through 1 and locked, `clk_out` equals `clk_ref`.
- R6: A control write that takes effect clears the lock flag (status bit 0 and `locked`) from the next cycle, and keeps it low for exactly LOCK_CYCLES (default 16) reference cycles.
- R7: While unlocked, `clk_out` is 0. Once the lock returns, the new setting starts with its full low phase.
- R8: A control write with bit 14 set changes neither `clk_out` nor the lock flag, yet a read of the control register returns the written word.
- R9: A later control write with bit 14 clear applies its setting, which supersedes the pending one.
- R10: A control read returns bits [14:0] of the last control write with bits [31:15] as 0. A status read has bits [31:1] as 0.
- R11: A control write that takes effect during the lock window restarts the full window.
- R12: A write to the status address changes no setting, no read-back and not the lock flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; also clocks the register bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (2) | Word address: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| clk_out | output | 1 | Divided or passed-through clock |
| locked | output | 1 | Lock flag, same as status bit 0 |

## Verification
The output is sampled in both halves of every reference cycle and compared with a model of the phase counts. An even split with no phase shift is checked against the same odd ratio with and without phase shift, which shows whether the falling edge really moves by half a cycle. A lopsided split such as 1/3 separates the independent low and high counts from a plain divide-by-N. Writes with deferral set, writes landing inside a running lock window, and writes to the status address are each followed by cycle-exact checks of the lock flag and of the output phase, which shows whether a setting took effect early, late or not at all.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Shared field layout of the divider control word.
// Assumes the bit positions are fixed by software that builds the word.
package clkdiv_pkg;
    localparam int PHASE_W   = 6;
    localparam int CTRL_W    = 15;
    localparam int NOUPD_BIT = 14;
    localparam int CFG_W     = 2 + 2 * PHASE_W;

    // Applied divider setting, bits [13:0] of the control word.
    typedef struct packed {
        logic               bypass;
        logic               edge_sel;
        logic [PHASE_W-1:0] high;
        logic [PHASE_W-1:0] low;
    } div_cfg_t;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 15'h2000;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
// Register file: control shadow, applied setting, read mux.
// Assumes a single-cycle write strobe synchronous to clk.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              lock_i,
    output logic [31:0]       bus_rdata,
    output div_cfg_t          act_cfg,
    output logic              apply_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_wr;
    logic              unused_rsvd;

    assign unused_rsvd = ^bus_wdata[31:CTRL_W];
    assign ctrl_wr     = bus_we && (bus_addr == CTRL_ADDR);
    assign apply_o     = ctrl_wr && !bus_wdata[NOUPD_BIT];

    // Keep the last written control word for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    // Load the setting the divider runs on, only on an applying write.
    always_ff @(posedge clk) begin
        if (!rst_n)       act_cfg <= div_cfg_t'(CTRL_RESET[CFG_W-1:0]);
        else if (apply_o) act_cfg <= div_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Select read data by word address.
    always_comb begin
        case (bus_addr)
            CTRL_ADDR: bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
            STAT_ADDR: bus_rdata = {31'b0, lock_i};
            default:   bus_rdata = '0;
        endcase
    end

    // R8: a deferred write leaves the running setting untouched.
    a_r8_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[NOUPD_BIT]) |=> $stable(act_cfg));
endmodule

// File: rtl/clkdiv_lock.sv
`timescale 1ns/1ps
// Lock window timer: reloaded on each applied write, lock flag high at zero.
// Assumes LOCK_CYCLES >= 1.
module clkdiv_lock #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic apply_i,
    output logic lock_o
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_CYCLES);

    logic [CW-1:0] wait_q;

    // Count down the settle window, restarting on every applied write.
    always_ff @(posedge clk) begin
        if (!rst_n)              wait_q <= '0;
        else if (apply_i)        wait_q <= LOAD;
        else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
    end

    assign lock_o = (wait_q == '0);

    // R6: an applied write drops the lock on the next cycle.
    a_r6_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        apply_i |=> !lock_o);
    // R11: a write inside the window keeps the lock low.
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && !lock_o) |=> !lock_o);
    // R6: lock only comes back when no write arrived in the prior cycle.
    a_r6_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> !$past(apply_i));
endmodule

// File: rtl/clkdiv_phase.sv
`timescale 1ns/1ps
// Phase counter producing the divided waveform, plus the half-cycle
// falling-edge delay stage. Assumes low >= 1 and low + high >= 2.
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PHASE_W-1:0] low,
    input  logic [PHASE_W-1:0] high,
    input  logic               edge_sel,
    output logic               div_o
);
    localparam int RW = PHASE_W + 1;

    logic [RW-1:0] ratio;
    logic [RW-1:0] pcnt;
    logic [RW-1:0] pnext;
    logic          q_pos;
    logic          q_neg;

    assign ratio = {1'b0, low} + {1'b0, high};
    assign pnext = (pcnt >= ratio - 1'b1) ? '0 : pcnt + 1'b1;

    // Advance the phase count; hold at the start of the low phase when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt  <= '0;
            q_pos <= 1'b0;
        end else begin
            pcnt  <= pnext;
            q_pos <= (pnext >= {1'b0, low});
        end
    end

    // Re-time the waveform on the falling reference edge for the shifted mode.
    always_ff @(negedge clk) begin
        if (!rst_n) q_neg <= 1'b0;
        else        q_neg <= q_pos;
    end

    assign div_o = edge_sel ? (q_pos | q_neg) : q_pos;

    // R7: a stopped divider restarts from its low phase.
    a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!q_pos && pcnt == '0));
    // R2: the count stays inside one period.
    a_r2_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ratio != '0) |-> pcnt < ratio);
endmodule

// File: rtl/clkdiv_stage.sv
`timescale 1ns/1ps
// Top of the programmable divider stage: registers, lock timer, phase
// counter and output select. Assumes the bus runs on clk_ref.
module clkdiv_stage
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int LOCK_CYCLES = 16
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              clk_out,
    output logic              locked
);
    div_cfg_t act_cfg;
    logic     apply;
    logic     div_clk;

    clkdiv_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .lock_i   (locked),
        .bus_rdata(bus_rdata),
        .act_cfg  (act_cfg),
        .apply_o  (apply)
    );

    clkdiv_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .apply_i(apply),
        .lock_o (locked)
    );

    clkdiv_phase u_phase (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .run     (locked),
        .low     (act_cfg.low),
        .high    (act_cfg.high),
        .edge_sel(act_cfg.edge_sel),
        .div_o   (div_clk)
    );

    // Gate the output off while unlocked; pick pass-through or divided clock.
    always_comb begin
        clk_out = locked & (act_cfg.bypass ? clk_ref : div_clk);
    end

    // R7: no output activity in the lock window.
    a_r7_quiet_unlocked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !locked |-> !clk_out);
endmodule

// File: tb/clkdiv_stage_bench.sv
`timescale 1ns/1ps
module clkdiv_stage_bench;
    localparam int LOCKN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;
    logic        locked;

    clkdiv_stage u_clkdiv_stage (
        .clk_ref(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_out(clk_out), .locked(locked)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int          c;
        bit          h;
        bit          sig;
        logic [31:0] v;
        string       tag;
    } item_t;
    item_t sb[$];

    // Reference model of the applied setting.
    int m_ce = -1000;
    int m_lo = 0;
    int m_hi = 0;
    bit m_edge = 1'b0;
    bit m_byp = 1'b1;

    function automatic bit exp_clk(int c, bit h);
        int j, n, k, kp;
        bit q, qp;
        if (c < m_ce + LOCKN) return 1'b0;
        if (m_byp) return (h == 1'b0);
        j = c - m_ce - LOCKN;
        n = m_lo + m_hi;
        k = j % n;
        q = (k >= m_lo);
        if (h || !m_edge) return q;
        kp = (k == 0) ? n - 1 : k - 1;
        qp = (j == 0) ? 1'b0 : (kp >= m_lo);
        return q | qp;
    endfunction

    task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: cyc %0d got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    // Monitor: pops scoreboard items as their cycle and half come up.
    task automatic take(bit h);
        while (sb.size() > 0 && (sb[0].c < cyc || (sb[0].c == cyc && sb[0].h <= h))) begin
            item_t it = sb.pop_front();
            if (it.c != cyc || it.h != h)
                check(32'hdead, it.v, {it.tag, " (missed)"});
            else if (it.sig)
                check(bus_rdata, it.v, it.tag);
            else
                check({31'b0, clk_out}, it.v, it.tag);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #2; take(1'b0);
            @(negedge clk); #2; take(1'b1);
        end
    end

    // Driver: push expected output and status for the next n cycles, then drain.
    task automatic expect_span(int n, string tag);
        for (int c = cyc + 1; c <= cyc + n; c++) begin
            sb.push_back('{c, 1'b0, 1'b0, {31'b0, exp_clk(c, 1'b0)}, tag});
            sb.push_back('{c, 1'b0, 1'b1, {31'b0, (c >= m_ce + LOCKN)}, {tag, " lock"}});
            sb.push_back('{c, 1'b1, 1'b0, {31'b0, exp_clk(c, 1'b1)}, tag});
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd1;
        if (a == 2'd0 && !d[14]) begin
            m_ce = cyc; m_lo = int'(d[5:0]); m_hi = int'(d[11:6]);
            m_edge = d[12]; m_byp = d[13];
        end
    endtask

    task automatic bus_read(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        #1 bus_addr = a;
        #1 check(bus_rdata, exp, tag);
        #1 bus_addr = 2'd1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check({31'b0, locked}, 32'd1, "R1 locked");
        bus_read(2'd0, 32'h0000_2000, "R1 ctrl reset");
        bus_read(2'd1, 32'h0000_0001, "R1 status reset");
        expect_span(4, "R1 pass-through after reset");
        // R2 R3 R6 R7: even ratio 4 split 2/2
        bus_write(2'd0, 32'h0000_0082);
        expect_span(LOCKN + 14, "R3 even ratio 4");
        bus_read(2'd0, 32'h0000_0082, "R10 ctrl readback");
        // R4: odd ratio 5, shifted falling edge
        bus_write(2'd0, 32'h0000_1083);
        expect_span(LOCKN + 16, "R4 ratio 5 shifted");
        // R2: same ratio without shift
        bus_write(2'd0, 32'h0000_0083);
        expect_span(LOCKN + 16, "R2 ratio 5 unshifted");
        // R2: lopsided 1/3 split
        bus_write(2'd0, 32'h0000_00C1);
        expect_span(LOCKN + 13, "R2 split 1/3");
        // R8: deferred write of ratio 6 does not take effect
        bus_write(2'd0, 32'h0000_40C3);
        expect_span(12, "R8 deferred no effect");
        bus_read(2'd0, 32'h0000_40C3, "R8 readback of deferred word");
        bus_read(2'd1, 32'h0000_0001, "R8 still locked");
        // R9: applying write takes over
        bus_write(2'd0, 32'h0000_00C3);
        expect_span(LOCKN + 19, "R9 applied ratio 6");
        // R11: write inside the lock window restarts it
        bus_write(2'd0, 32'h0000_0082);
        expect_span(5, "R11 first window");
        bus_write(2'd0, 32'h0000_10C4);
        expect_span(LOCKN + 22, "R11 restarted window ratio 7");
        // R12: status write ignored
        bus_write(2'd1, 32'h0000_0000);
        expect_span(10, "R12 status write no effect");
        bus_read(2'd0, 32'h0000_10C4, "R12 ctrl unchanged");
        // R10: reserved bits read as zero
        bus_write(2'd0, 32'hFFFF_4082);
        bus_read(2'd0, 32'h0000_4082, "R10 reserved bits zero");
        expect_span(6, "R10 deferred ratio kept");
        // R5: ratio 1 as pass-through
        bus_write(2'd0, 32'h0000_2000);
        expect_span(LOCKN + 6, "R5 pass-through");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cyc %0d got hung expected done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule